// File: doc/BRIEF.md
# Two-Queue Conversion Command Sequencer

This block walks a 64-entry table of conversion commands for an analog-to-digital converter. Each command names an input channel in 6 bits and carries a stop-here (pause) bit. The table is shared by two queues. Queue 1 always starts at entry 0. Queue 2 starts at a 7-bit begin pointer. Each queue has its own trigger. For every command it runs, the block sends a one-cycle start pulse and the channel number to the converter. It then waits for the converter's done pulse and writes the 10-bit result into a result table, at the same index as the command.

A queue stops in one of two ways. At a pause command, it stops in the paused state once that command's conversion has finished, and the next trigger resumes it at the following entry. At an end-of-queue condition, it goes back to idle. There are three end-of-queue conditions: the reserved channel code, queue 1 running into the start of queue 2, and running off the end of the table. Both queues have a sticky pause flag and a sticky completion flag. Each flag is cleared by a write-one-to-clear pulse and drives an interrupt output through its own enable.

Top module: `adcq_top`

## Requirements
- R1: After reset, both queue statuses read 0 (idle), all pause and completion flags and all interrupt outputs are 0, and conv_start is 0. Status is encoded as 0 idle, 1 active, 2 paused.
- R2: Each executed command gives exactly one conv_start pulse of one cycle, with conv_chan equal to the command's channel field. Commands run in ascending index order. The conv_result that comes with the following conv_done is stored at that command's index, where res_rd_idx/res_rd_data can read it.
- R3: A command with channel code 63 ends the running queue without a conversion. This also holds when it is the first command read after a trigger. The queue's completion flag is set and its status returns to idle.
- R4: A command with its pause bit set is converted first. The queue then sets its pause flag and its status becomes 2 (paused).
- R5: A trigger to a paused queue resumes it at the entry that follows the paused command.
- R6: If a paused command is followed at once by an end-of-queue condition, both the pause and completion flags are set and the status becomes idle, not paused. This includes a pause on entry 63.
- R7: Queue 1 ends, with no conversion, when it reaches the entry equal to the queue 2 begin pointer. With a begin pointer of 0, a queue 1 trigger converts nothing.
- R8: Going past entry 63 is an end-of-queue condition. Queue 2 begun at 63 converts entry 63 only, then completes.
- R9: A queue 2 begin pointer of 64 to 127 makes a queue 2 trigger complete at once, with no conversion.
- R10: When a queue ends, only that queue's completion flag is set, even if several end conditions hold at the same moment.
- R11: Queue 1 has priority, and at most one queue is active at a time. A queue 2 trigger that arrives while queue 1 is active leaves queue 2 idle until queue 1 stops. Queue 2 then runs.
- R12: Flags stay set until the matching bit of flag_clr_pause / flag_clr_done is pulsed. Bit 0 belongs to queue 1 and bit 1 to queue 2. Each interrupt bit is the flag ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ccw_wr_en | input | 1 | Write strobe for the command table |
| ccw_wr_idx | input | 6 | Command table write index |
| ccw_wr_chan | input | 6 | Channel field to write (63 = end of queue) |
| ccw_wr_pause | input | 1 | Pause bit to write |
| q2_begin | input | 7 | Begin pointer of queue 2 |
| trig_q1 | input | 1 | Trigger pulse for queue 1 |
| trig_q2 | input | 1 | Trigger pulse for queue 2 |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 6 | Channel for the request |
| conv_done | input | 1 | Converter finished pulse |
| conv_result | input | 10 | Converter result, valid with conv_done |
| res_rd_idx | input | 6 | Result table read index |
| res_rd_data | output | 10 | Result table read data |
| q1_status | output | 2 | Queue 1 status |
| q2_status | output | 2 | Queue 2 status |
| pause_flag | output | 2 | Sticky pause flags, bit 0 = queue 1 |
| done_flag | output | 2 | Sticky completion flags, bit 0 = queue 1 |
| flag_clr_pause | input | 2 | Write-one-to-clear for pause flags |
| flag_clr_done | input | 2 | Write-one-to-clear for completion flags |
| irq_en_pause | input | 2 | Pause interrupt enables |
| irq_en_done | input | 2 | Completion interrupt enables |
| irq_pause | output | 2 | Pause interrupts |
| irq_done | output | 2 | Completion interrupts |

## Verification
The bench targets the ways a queue can end: a pause directly before an end-of-queue code, a pause on the last table entry, an end-of-queue code as the very first command, a queue 2 begin pointer of 0, 63 and above 63, and a pending queue 2 trigger while queue 1 runs. A design that checks end-of-queue only before converting would leave a queue paused where it should be idle. A design that fetches the first command before testing the begin pointer would issue a spurious conversion, which the scoreboard reports as an unexpected start. Wrong resume indexing or a lost pending trigger shows up as a mismatch in the expected order of channel requests or in the result-table contents.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  parameter int unsigned ENTRIES = 64;
  parameter int unsigned CHAN_W  = 6;
  parameter int unsigned RES_W   = 10;
  parameter int unsigned NUM_Q   = 2;
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned PTR_W  = IDX_W + 1;
  localparam logic [CHAN_W-1:0] EOQ_CODE = {CHAN_W{1'b1}};

  typedef enum logic [1:0] {
    QS_IDLE   = 2'd0,
    QS_ACTIVE = 2'd1,
    QS_PAUSED = 2'd2
  } qstat_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_WAIT,
    SQ_PCHK
  } seq_e;
endpackage

// File: rtl/adcq_rst_sync.sv
module adcq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/adcq_regfile.sv
module adcq_regfile #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/adcq_flags.sv
module adcq_flags #(
  parameter int unsigned NQ = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] set_pause,
  input  logic [NQ-1:0] set_done,
  input  logic [NQ-1:0] clr_pause,
  input  logic [NQ-1:0] clr_done,
  input  logic [NQ-1:0] en_pause,
  input  logic [NQ-1:0] en_done,
  output logic [NQ-1:0] pause_flag,
  output logic [NQ-1:0] done_flag,
  output logic [NQ-1:0] irq_pause,
  output logic [NQ-1:0] irq_done
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic pf_q, pf_d, df_q, df_d;

    always_comb begin
      pf_d = (pf_q & ~clr_pause[q]) | set_pause[q];
      df_d = (df_q & ~clr_done[q])  | set_done[q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pf_q <= 1'b0;
        df_q <= 1'b0;
      end else begin
        pf_q <= pf_d;
        df_q <= df_d;
      end
    end

    assign pause_flag[q] = pf_q;
    assign done_flag[q]  = df_q;
    assign irq_pause[q]  = pf_q & en_pause[q];
    assign irq_done[q]   = df_q & en_done[q];

    AST_PAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_q && !clr_pause[q]) |=> pf_q); // R12
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (df_q && !clr_done[q]) |=> df_q); // R12
  end
endmodule

// File: rtl/adcq_sequencer.sv
module adcq_sequencer
  import adcq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_Q-1:0]           trig,
  input  logic [PTR_W-1:0]           q2_begin,
  input  logic [CHAN_W-1:0]          ccw_chan,
  input  logic                       ccw_pause,
  output logic [IDX_W-1:0]           rd_idx,
  output logic                       conv_start,
  output logic [CHAN_W-1:0]          conv_chan,
  input  logic                       conv_done,
  input  logic [RES_W-1:0]           conv_result,
  output logic                       res_we,
  output logic [IDX_W-1:0]           res_idx,
  output logic [RES_W-1:0]           res_data,
  output logic [NUM_Q-1:0]           set_pause,
  output logic [NUM_Q-1:0]           set_done,
  output logic [NUM_Q-1:0][1:0]      status
);
  seq_e               state_q, state_d;
  logic               cur_q, cur_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               pz_q, pz_d;
  logic [NUM_Q-1:0]   pend_q, pend_d;
  qstat_e             stat_q [NUM_Q];
  qstat_e             stat_d [NUM_Q];
  logic [PTR_W-1:0]   nxt_q  [NUM_Q];
  logic               nxt_en;
  logic               eoq;

  // Any end-of-queue condition for the entry under the pointer
  always_comb begin
    eoq = (ptr_q >= PTR_W'(ENTRIES))
        || (!cur_q && (ptr_q == q2_begin))
        || (ccw_chan == EOQ_CODE);
  end

  always_comb begin
    state_d    = state_q;
    cur_d      = cur_q;
    ptr_d      = ptr_q;
    pz_d       = pz_q;
    nxt_en     = 1'b0;
    set_pause  = '0;
    set_done   = '0;
    conv_start = 1'b0;
    res_we     = 1'b0;
    for (int q = 0; q < NUM_Q; q++) begin
      stat_d[q] = stat_q[q];
      pend_d[q] = pend_q[q] | (trig[q] && (stat_q[q] != QS_ACTIVE));
    end

    unique case (state_q)
      SQ_IDLE: begin
        if (pend_q[0]) begin
          cur_d     = 1'b0;
          ptr_d     = (stat_q[0] == QS_PAUSED) ? nxt_q[0] : '0;
          stat_d[0] = QS_ACTIVE;
          pend_d[0] = 1'b0;
          state_d   = SQ_FETCH;
        end else if (pend_q[1]) begin
          cur_d     = 1'b1;
          ptr_d     = (stat_q[1] == QS_PAUSED) ? nxt_q[1] : q2_begin;
          stat_d[1] = QS_ACTIVE;
          pend_d[1] = 1'b0;
          state_d   = SQ_FETCH;
        end
      end
      SQ_FETCH: begin
        if (eoq) begin
          set_done[cur_q] = 1'b1;
          stat_d[cur_q]   = QS_IDLE;
          state_d         = SQ_IDLE;
        end else begin
          conv_start = 1'b1;
          pz_d       = ccw_pause;
          state_d    = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (conv_done) begin
          res_we = 1'b1;
          ptr_d  = ptr_q + 1'b1;
          if (pz_q) begin
            set_pause[cur_q] = 1'b1;
            state_d          = SQ_PCHK;
          end else begin
            state_d = SQ_FETCH;
          end
        end
      end
      SQ_PCHK: begin
        if (eoq) begin
          set_done[cur_q] = 1'b1;
          stat_d[cur_q]   = QS_IDLE;
        end else begin
          stat_d[cur_q] = QS_PAUSED;
          nxt_en        = 1'b1;
        end
        state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cur_q   <= 1'b0;
      ptr_q   <= '0;
      pz_q    <= 1'b0;
      pend_q  <= '0;
      for (int q = 0; q < NUM_Q; q++) stat_q[q] <= QS_IDLE;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      ptr_q   <= ptr_d;
      pz_q    <= pz_d;
      pend_q  <= pend_d;
      for (int q = 0; q < NUM_Q; q++) stat_q[q] <= stat_d[q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NUM_Q; q++) nxt_q[q] <= '0;
    end else if (nxt_en) begin
      nxt_q[cur_q] <= ptr_q;
    end
  end

  assign rd_idx    = ptr_q[IDX_W-1:0];
  assign conv_chan = ccw_chan;
  assign res_idx   = ptr_q[IDX_W-1:0];
  assign res_data  = conv_result;
  for (genvar q = 0; q < NUM_Q; q++) begin : g_st
    assign status[q] = stat_q[q];
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R2
  AST_START_NEVER_EOQ: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_chan != EOQ_CODE)); // R3
endmodule

// File: rtl/adcq_top.sv
module adcq_top
  import adcq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ccw_wr_en,
  input  logic [IDX_W-1:0]   ccw_wr_idx,
  input  logic [CHAN_W-1:0]  ccw_wr_chan,
  input  logic               ccw_wr_pause,
  input  logic [PTR_W-1:0]   q2_begin,
  input  logic               trig_q1,
  input  logic               trig_q2,
  output logic               conv_start,
  output logic [CHAN_W-1:0]  conv_chan,
  input  logic               conv_done,
  input  logic [RES_W-1:0]   conv_result,
  input  logic [IDX_W-1:0]   res_rd_idx,
  output logic [RES_W-1:0]   res_rd_data,
  output logic [1:0]         q1_status,
  output logic [1:0]         q2_status,
  output logic [NUM_Q-1:0]   pause_flag,
  output logic [NUM_Q-1:0]   done_flag,
  input  logic [NUM_Q-1:0]   flag_clr_pause,
  input  logic [NUM_Q-1:0]   flag_clr_done,
  input  logic [NUM_Q-1:0]   irq_en_pause,
  input  logic [NUM_Q-1:0]   irq_en_done,
  output logic [NUM_Q-1:0]   irq_pause,
  output logic [NUM_Q-1:0]   irq_done
);
  localparam int unsigned CCW_W = CHAN_W + 1;

  logic                  rst_i_n;
  logic [IDX_W-1:0]      ccw_rd_idx;
  logic [CCW_W-1:0]      ccw_rd;
  logic                  res_we;
  logic [IDX_W-1:0]      res_idx;
  logic [RES_W-1:0]      res_data;
  logic [NUM_Q-1:0]      set_pause, set_done;
  logic [NUM_Q-1:0][1:0] status;

  adcq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  adcq_regfile #(.DEPTH(ENTRIES), .WIDTH(CCW_W)) u_ccw (
    .clk(clk), .wr_en(ccw_wr_en), .wr_idx(ccw_wr_idx),
    .wr_data({ccw_wr_pause, ccw_wr_chan}),
    .rd_idx(ccw_rd_idx), .rd_data(ccw_rd)
  );

  adcq_regfile #(.DEPTH(ENTRIES), .WIDTH(RES_W)) u_res (
    .clk(clk), .wr_en(res_we), .wr_idx(res_idx), .wr_data(res_data),
    .rd_idx(res_rd_idx), .rd_data(res_rd_data)
  );

  adcq_sequencer u_seq (
    .clk(clk), .rst_n(rst_i_n), .trig({trig_q2, trig_q1}),
    .q2_begin(q2_begin), .ccw_chan(ccw_rd[CHAN_W-1:0]),
    .ccw_pause(ccw_rd[CHAN_W]), .rd_idx(ccw_rd_idx),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result),
    .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
    .set_pause(set_pause), .set_done(set_done), .status(status)
  );

  adcq_flags #(.NQ(NUM_Q)) u_flags (
    .clk(clk), .rst_n(rst_i_n), .set_pause(set_pause), .set_done(set_done),
    .clr_pause(flag_clr_pause), .clr_done(flag_clr_done),
    .en_pause(irq_en_pause), .en_done(irq_en_done),
    .pause_flag(pause_flag), .done_flag(done_flag),
    .irq_pause(irq_pause), .irq_done(irq_done)
  );

  assign q1_status = status[0];
  assign q2_status = status[1];

  AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !((q1_status == 2'd1) && (q2_status == 2'd1))); // R11
  AST_Q1_PAUSE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(pause_flag[0]) |-> ($past(q1_status) == 2'd1)); // R4
  AST_Q2_PAUSE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(pause_flag[1]) |-> ($past(q2_status) == 2'd1)); // R4
  AST_Q1_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(done_flag[0]) |-> (q1_status == 2'd0)); // R3
  AST_Q2_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(done_flag[1]) |-> (q2_status == 2'd0)); // R3
endmodule

// File: tb/adcq_top_bench.sv
module adcq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ccw_wr_en = 1'b0;
  logic [5:0] ccw_wr_idx = '0;
  logic [5:0] ccw_wr_chan = '0;
  logic       ccw_wr_pause = 1'b0;
  logic [6:0] q2_begin = '0;
  logic       trig_q1 = 1'b0, trig_q2 = 1'b0;
  logic       conv_start;
  logic [5:0] conv_chan;
  logic       conv_done = 1'b0;
  logic [9:0] conv_result = '0;
  logic [5:0] res_rd_idx = '0;
  logic [9:0] res_rd_data;
  logic [1:0] q1_status, q2_status, pause_flag, done_flag;
  logic [1:0] flag_clr_pause = '0, flag_clr_done = '0;
  logic [1:0] irq_en_pause = '0, irq_en_done = '0;
  logic [1:0] irq_pause, irq_done;

  always #4 clk = ~clk;

  adcq_top u_adcq_top (.*);

  int nchk = 0;
  int nerr = 0;
  logic [5:0] mchan [64];
  logic [9:0] exp_res [64];
  int expq[$];
  int resq[$];
  int mseq = 0;
  int stub_seq = 0;
  int stub_cnt = 0;
  logic stub_busy = 1'b0;
  logic [5:0] stub_chan = '0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected command indices as conversion requests appear
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      if (expq.size() == 0) begin
        chk("R2 unexpected conversion request, chan", int'(conv_chan), -1);
      end else begin
        int idx;
        idx = expq.pop_front();
        chk("R2 conversion channel order", int'(conv_chan), int'(mchan[idx]));
        exp_res[idx] = {mseq[3:0], mchan[idx]};
        mseq++;
        resq.push_back(idx);
      end
    end
  end

  // Converter stub
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (stub_busy) begin
      if (stub_cnt == 0) begin
        conv_done   = 1'b1;
        conv_result = {stub_seq[3:0], stub_chan};
        stub_seq++;
        stub_busy = 1'b0;
      end else begin
        stub_cnt--;
      end
    end
    if (rst_n && conv_start) begin
      stub_busy = 1'b1;
      stub_cnt  = 2;
      stub_chan = conv_chan;
    end
  end

  task automatic wr_ccw(input int idx, input int chan, input bit pz);
    @(negedge clk);
    ccw_wr_en = 1'b1; ccw_wr_idx = 6'(idx); ccw_wr_chan = 6'(chan); ccw_wr_pause = pz;
    mchan[idx] = 6'(chan);
    @(negedge clk);
    ccw_wr_en = 1'b0;
  endtask

  task automatic restore(input int idx);
    wr_ccw(idx, (idx == 63) ? 1 : idx, 1'b0);
  endtask

  task automatic fire(input bit t1, input bit t2);
    @(negedge clk);
    trig_q1 = t1; trig_q2 = t2;
    @(negedge clk);
    trig_q1 = 1'b0; trig_q2 = 1'b0;
  endtask

  task automatic expect_run(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) expq.push_back(i);
  endtask

  task automatic wait_quiet();
    int calm = 0;
    while (calm < 10) begin
      @(negedge clk);
      if (q1_status != 2'd1 && q2_status != 2'd1 && !conv_start && !stub_busy) calm++;
      else calm = 0;
    end
  endtask

  task automatic check_results(input string req);
    chk({req, " all expected conversions issued"}, expq.size(), 0);
    while (resq.size() > 0) begin
      int idx;
      idx = resq.pop_front();
      res_rd_idx = 6'(idx);
      #1;
      chk({req, " result stored at command index"}, int'(res_rd_data), int'(exp_res[idx]));
    end
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr_pause = 2'b11; flag_clr_done = 2'b11;
    @(negedge clk);
    flag_clr_pause = 2'b00; flag_clr_done = 2'b00;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 q1_status", q1_status, 0);
    chk("R1 q2_status", q2_status, 0);
    chk("R1 pause_flag", pause_flag, 0);
    chk("R1 done_flag", done_flag, 0);
    chk("R1 irq", {irq_pause, irq_done}, 0);
    chk("R1 conv_start", conv_start, 0);
    for (int i = 0; i < 64; i++) restore(i);

    // R2/R7: queue 1 stops at queue 2 begin
    q2_begin = 7'd8;
    expect_run(0, 7); fire(1, 0); wait_quiet();
    check_results("R2");
    chk("R7 q1 idle", q1_status, 0);
    chk("R7 q1 done flag", done_flag, 2'b01);
    chk("R10 pause untouched", pause_flag, 0);
    clear_flags();

    // R3: end code inside queue 2
    wr_ccw(11, 63, 1'b0);
    expect_run(8, 10); fire(0, 1); wait_quiet();
    check_results("R3");
    chk("R3 q2 done only", done_flag, 2'b10);
    chk("R3 q2 idle", q2_status, 0);
    restore(11); clear_flags();

    // R4/R5: pause then resume
    q2_begin = 7'd20; wr_ccw(2, 2, 1'b1);
    expect_run(0, 2); fire(1, 0); wait_quiet();
    check_results("R4");
    chk("R4 q1 paused", q1_status, 2);
    chk("R4 pause flag", pause_flag, 2'b01);
    chk("R4 no completion", done_flag, 0);
    expect_run(3, 19); fire(1, 0); wait_quiet();
    check_results("R5");
    chk("R5 q1 idle after resume", q1_status, 0);
    chk("R5 q1 done", done_flag, 2'b01);
    restore(2); clear_flags();

    // R6: pause followed by end code
    wr_ccw(5, 5, 1'b1); wr_ccw(6, 63, 1'b0);
    expect_run(0, 5); fire(1, 0); wait_quiet();
    check_results("R6");
    chk("R6 q1 idle not paused", q1_status, 0);
    chk("R6 both flags", {pause_flag, done_flag}, 4'b0101);
    restore(5); restore(6); clear_flags();

    // R3: first command is the end code
    wr_ccw(0, 63, 1'b0);
    fire(1, 0); wait_quiet();
    check_results("R3");
    chk("R3 first-entry end, done", done_flag, 2'b01);
    chk("R3 first-entry end, idle", q1_status, 0);
    restore(0); clear_flags();

    // R7/R10: begin pointer 0
    q2_begin = 7'd0;
    fire(1, 0); wait_quiet();
    check_results("R7");
    chk("R10 only q1 completion", done_flag, 2'b01);
    clear_flags();

    // R8: queue 2 at last entry
    q2_begin = 7'd63;
    expect_run(63, 63); fire(0, 1); wait_quiet();
    check_results("R8");
    chk("R8 q2 done", done_flag, 2'b10);
    chk("R8 q2 idle", q2_status, 0);
    clear_flags();

    // R9: begin pointer beyond table
    q2_begin = 7'd100;
    fire(0, 1); wait_quiet();
    check_results("R9");
    chk("R9 q2 done, no conversion", done_flag, 2'b10);
    clear_flags();

    // R6: pause on entry 63
    q2_begin = 7'd63; wr_ccw(63, 7, 1'b1);
    expect_run(63, 63); fire(0, 1); wait_quiet();
    check_results("R6");
    chk("R6 pause at table end idle", q2_status, 0);
    chk("R6 pause at table end flags", {pause_flag, done_flag}, 4'b1010);
    restore(63); clear_flags();

    // R11: simultaneous triggers, queue 1 first
    q2_begin = 7'd4; wr_ccw(10, 63, 1'b0);
    expect_run(0, 3); expect_run(4, 9); fire(1, 1); wait_quiet();
    check_results("R11");
    chk("R11 both complete", done_flag, 2'b11);
    clear_flags();
    // R11: queue 2 trigger during queue 1 run
    expect_run(0, 3); expect_run(4, 9);
    fire(1, 0); repeat (3) @(negedge clk);
    fire(0, 1);
    chk("R11 q2 held idle while q1 active", q2_status, 0);
    chk("R11 q1 still active", q1_status, 1);
    wait_quiet();
    check_results("R11");
    chk("R11 pending q2 ran", done_flag, 2'b11);

    // R12: sticky flags, interrupt gating, write-one-to-clear
    irq_en_done = 2'b01;
    repeat (20) @(negedge clk);
    chk("R12 flags stay set", done_flag, 2'b11);
    chk("R12 irq gated by enable", irq_done, 2'b01);
    @(negedge clk); flag_clr_done = 2'b01;
    @(negedge clk); flag_clr_done = 2'b00;
    chk("R12 w1c clears only bit 0", done_flag, 2'b10);
    chk("R12 irq follows flag", irq_done, 2'b00);
    restore(10);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule